// File: doc/BRIEF.md
# Whole-Cell FIFO with Start-Position Checking

This block holds fixed-length cells between a line-side writer and a packet-style reader on one clock. The writer presents one word per cycle with a start marker on the first word of each cell. Before starting a cell it looks at a room flag, which is high only while a complete cell still fits. The reader looks at a flag that says at least one finished cell is waiting. It then pulls words with an enable and gets back data, a valid strobe, first-word and last-word markers and a per-word error bit. A cell can be read only after its final word has been written, so the reader never sees a partial cell.

Storage is organised as a ring of cell slots, each slot as many words deep as a cell. The write side is a three-state machine:
- W_IDLE waits for a cell start.
- W_BODY collects the remaining words of an accepted cell.
- W_DROP swallows a cell that began without room.

Its transitions are:
- W_IDLE→W_BODY: a start with room.
- W_IDLE→W_DROP: a start without room.
- W_BODY→W_BODY: a misplaced start marker. The partial cell is rolled back and the marked word becomes word 0.
- W_BODY→W_IDLE: the last word commits the cell.
- W_DROP→W_BODY: a start marker arrives and there is room.
- W_DROP→W_IDLE: the dropped cell's last word.

The read side has two states:
- R_HEAD: the next word is the first of a cell.
- R_BODY: reading is inside a cell.

It moves R_HEAD→R_BODY on the first word taken and R_BODY→R_HEAD when the last word is taken, which frees the slot.

Top module: `cell_fifo`

## Requirements
- R1: After reset, cell_space is 1 and rd_dav, rd_val, cell_written, oflw_err, soc_err and uflw_err are all 0.
- R2: cell_space is 1 exactly when the number of committed unread cells, plus one if a cell is being collected (W_BODY), is less than DEPTH_CELLS (default 4).
- R3: A cell start seen while cell_space is 0 raises oflw_err for one cycle in the following cycle. That cell's words (CELL_WORDS of them, or fewer if a start marker comes earlier) are discarded and never reach the reader.
- R4: cell_written pulses for exactly one cycle, in the cycle after the last word (index CELL_WORDS-1, default 12) of each accepted cell is written.
- R5: rd_dav is 1 exactly when at least one fully written cell has not been fully read. It rises in the same cycle as the matching cell_written pulse and never earlier.
- R6: If rd_ena is 1 while rd_dav is 0, uflw_err is 1 in the next cycle and rd_val is 0.
- R7: rd_ena=1 with rd_dav=1 yields rd_val=1 with the next word of the cell in the following cycle. rd_ena=0 yields rd_val=0 and the read position does not move.
- R8: On the reader side, rd_sop is 1 on word index 0 and rd_eop is 1 on word index CELL_WORDS-1 of every cell.
- R9: A word with wr_sop=1 at word index 1 to CELL_WORDS-1 of a cell being collected raises soc_err in the next cycle. The partial cell is dropped, and that word becomes word 0 of a new clean cell.
- R10: A cell whose first word arrives with wr_sop=0 raises soc_err in the next cycle but is still stored. rd_err is 1 on all of its words. rd_err is 0 on every word of a cell that started with wr_sop=1.
- R11: Cells are read in the order they were committed, and the data words of each cell come back unchanged and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Writer presents a word this cycle |
| wr_sop | input | 1 | Word is the first of a cell |
| wr_data | input | DATA_W | Write word |
| cell_space | output | 1 | A complete cell fits |
| cell_written | output | 1 | One-cycle pulse per accepted cell |
| oflw_err | output | 1 | Cell start refused for lack of room |
| soc_err | output | 1 | Start marker missing or misplaced |
| rd_ena | input | 1 | Reader takes a word this cycle |
| rd_dav | output | 1 | At least one full cell is readable |
| rd_val | output | 1 | rd_data carries a word |
| rd_data | output | DATA_W | Read word |
| rd_sop | output | 1 | Read word is word 0 of its cell |
| rd_eop | output | 1 | Read word is the last of its cell |
| rd_err | output | 1 | Read word belongs to a faulty cell |
| uflw_err | output | 1 | Read requested with no full cell |

## Verification
The checker assumes that wr_en, wr_sop and rd_ena carry known values from the first edge after reset.

Its shadow cell count is built only from cell_written pulses and read-side last-word strobes. That count is valid only if every accepted cell is eventually read out whole.

The bench drives all inputs one nanosecond after the rising edge, so they never change at the edge. It reads each cell to its end before starting on the next check, and it never queues more cells than the configured depth, except for the deliberate overflow attempt.

// File: rtl/cell_fifo_pkg.sv
package cell_fifo_pkg;

    typedef enum logic [1:0] {
        W_IDLE,
        W_BODY,
        W_DROP
    } wr_state_t;

    typedef enum logic {
        R_HEAD,
        R_BODY
    } rd_state_t;

endpackage

// File: rtl/cell_fifo_store.sv
module cell_fifo_store #(
    parameter int DATA_W      = 32,
    parameter int CELL_WORDS  = 13,
    parameter int DEPTH_CELLS = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [$clog2(DEPTH_CELLS)-1:0]        wslot,
    input  logic [$clog2(CELL_WORDS)-1:0]         widx,
    input  logic [DATA_W-1:0]                     wdata,
    input  logic                                  werr,
    input  logic                                  re,
    input  logic [$clog2(DEPTH_CELLS)-1:0]        rslot,
    input  logic [$clog2(CELL_WORDS)-1:0]         ridx,
    output logic [DATA_W-1:0]                     rdata,
    output logic                                  rerr
);
    localparam int ENTRIES = CELL_WORDS * DEPTH_CELLS;
    localparam int ADDR_W  = $clog2(ENTRIES);

    logic [DATA_W:0]   mem [ENTRIES];
    logic [DATA_W:0]   q;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;

    // slot base plus word offset
    always_comb begin
        waddr = ADDR_W'(wslot) * ADDR_W'(CELL_WORDS) + ADDR_W'(widx);
        raddr = ADDR_W'(rslot) * ADDR_W'(CELL_WORDS) + ADDR_W'(ridx);
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {werr, wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (re) begin
            q <= mem[raddr];
        end
    end

    assign rdata = q[DATA_W-1:0];
    assign rerr  = q[DATA_W];

endmodule

// File: rtl/cell_fifo_wr.sv
module cell_fifo_wr
    import cell_fifo_pkg::*;
#(
    parameter int CELL_WORDS  = 13,
    parameter int DEPTH_CELLS = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic                                  wr_sop,
    input  logic [$clog2(DEPTH_CELLS+1)-1:0]      cells_held,
    output logic                                  mem_we,
    output logic [$clog2(DEPTH_CELLS)-1:0]        mem_wslot,
    output logic [$clog2(CELL_WORDS)-1:0]         mem_widx,
    output logic                                  mem_werr,
    output logic                                  commit,
    output logic                                  cell_space,
    output logic                                  cell_written,
    output logic                                  oflw_err,
    output logic                                  soc_err
);
    localparam int IDX_W  = $clog2(CELL_WORDS);
    localparam int SLOT_W = $clog2(DEPTH_CELLS);
    localparam int CNT_W  = $clog2(DEPTH_CELLS+1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_WORDS-1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH_CELLS-1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(DEPTH_CELLS);
    localparam logic [CNT_W-1:0]  NEAR_CNT  = CNT_W'(DEPTH_CELLS-1);

    wr_state_t         state, nstate;
    logic [IDX_W-1:0]  widx, n_idx;
    logic [SLOT_W-1:0] wslot;
    logic              cell_bad, n_bad;
    logic              room;
    logic              ovf, socf;

    always_comb begin
        room       = cells_held < FULL_CNT;
        cell_space = (state == W_BODY) ? (cells_held < NEAR_CNT) : room;
    end

    // next-state and datapath strobes
    always_comb begin
        nstate   = state;
        n_idx    = widx;
        n_bad    = cell_bad;
        mem_we   = 1'b0;
        mem_widx = widx;
        mem_werr = cell_bad;
        commit   = 1'b0;
        ovf      = 1'b0;
        socf     = 1'b0;
        unique case (state)
            W_IDLE: begin
                if (wr_en) begin
                    socf  = !wr_sop;
                    n_idx = IDX_W'(1);
                    if (room) begin
                        mem_we   = 1'b1;
                        mem_widx = '0;
                        mem_werr = !wr_sop;
                        n_bad    = !wr_sop;
                        nstate   = W_BODY;
                    end else begin
                        ovf    = 1'b1;
                        nstate = W_DROP;
                    end
                end
            end
            W_BODY: begin
                if (wr_en) begin
                    mem_we = 1'b1;
                    if (wr_sop) begin
                        // roll back: restart the same slot at word 0
                        socf     = 1'b1;
                        mem_widx = '0;
                        mem_werr = 1'b0;
                        n_bad    = 1'b0;
                        n_idx    = IDX_W'(1);
                    end else if (widx == LAST_IDX) begin
                        commit = 1'b1;
                        n_idx  = '0;
                        n_bad  = 1'b0;
                        nstate = W_IDLE;
                    end else begin
                        n_idx = widx + IDX_W'(1);
                    end
                end
            end
            W_DROP: begin
                if (wr_en) begin
                    if (wr_sop) begin
                        n_idx = IDX_W'(1);
                        if (room) begin
                            mem_we   = 1'b1;
                            mem_widx = '0;
                            mem_werr = 1'b0;
                            n_bad    = 1'b0;
                            nstate   = W_BODY;
                        end else begin
                            ovf = 1'b1;
                        end
                    end else if (widx == LAST_IDX) begin
                        n_idx  = '0;
                        nstate = W_IDLE;
                    end else begin
                        n_idx = widx + IDX_W'(1);
                    end
                end
            end
            default: begin
                nstate = W_IDLE;
                n_idx  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            widx     <= '0;
            cell_bad <= 1'b0;
            wslot    <= '0;
        end else begin
            state    <= nstate;
            widx     <= n_idx;
            cell_bad <= n_bad;
            if (commit) begin
                wslot <= (wslot == LAST_SLOT) ? '0 : wslot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_written <= 1'b0;
            oflw_err     <= 1'b0;
            soc_err      <= 1'b0;
        end else begin
            cell_written <= commit;
            oflw_err     <= ovf;
            soc_err      <= socf;
        end
    end

    assign mem_wslot = wslot;

endmodule

// File: rtl/cell_fifo_rd.sv
module cell_fifo_rd
    import cell_fifo_pkg::*;
#(
    parameter int CELL_WORDS  = 13,
    parameter int DEPTH_CELLS = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rd_ena,
    input  logic [$clog2(DEPTH_CELLS+1)-1:0]      cells_held,
    output logic                                  rd_dav,
    output logic                                  take,
    output logic                                  release_cell,
    output logic [$clog2(DEPTH_CELLS)-1:0]        rslot,
    output logic [$clog2(CELL_WORDS)-1:0]         ridx,
    output logic                                  rd_val,
    output logic                                  rd_sop,
    output logic                                  rd_eop,
    output logic                                  uflw_err
);
    localparam int IDX_W  = $clog2(CELL_WORDS);
    localparam int SLOT_W = $clog2(DEPTH_CELLS);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_WORDS-1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH_CELLS-1);

    rd_state_t        state, nstate;
    logic [IDX_W-1:0] n_idx;
    logic             at_last;

    always_comb begin
        rd_dav       = cells_held != '0;
        take         = rd_ena && rd_dav;
        at_last      = ridx == LAST_IDX;
        release_cell = take && at_last;
        nstate       = state;
        n_idx        = ridx;
        if (take) begin
            n_idx = at_last ? '0 : ridx + IDX_W'(1);
        end
        unique case (state)
            R_HEAD:  if (take)         nstate = R_BODY;
            R_BODY:  if (release_cell) nstate = R_HEAD;
            default: nstate = R_HEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= R_HEAD;
            ridx  <= '0;
            rslot <= '0;
        end else begin
            state <= nstate;
            ridx  <= n_idx;
            if (release_cell) begin
                rslot <= (rslot == LAST_SLOT) ? '0 : rslot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_val   <= 1'b0;
            rd_sop   <= 1'b0;
            rd_eop   <= 1'b0;
            uflw_err <= 1'b0;
        end else begin
            rd_val   <= take;
            rd_sop   <= take && (state == R_HEAD);
            rd_eop   <= release_cell;
            uflw_err <= rd_ena && !rd_dav;
        end
    end

endmodule

// File: rtl/cell_fifo.sv
module cell_fifo #(
    parameter int DATA_W      = 32,
    parameter int CELL_WORDS  = 13,
    parameter int DEPTH_CELLS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sop,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cell_space,
    output logic              cell_written,
    output logic              oflw_err,
    output logic              soc_err,
    input  logic              rd_ena,
    output logic              rd_dav,
    output logic              rd_val,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_eop,
    output logic              rd_err,
    output logic              uflw_err
);
    localparam int IDX_W  = $clog2(CELL_WORDS);
    localparam int SLOT_W = $clog2(DEPTH_CELLS);
    localparam int CNT_W  = $clog2(DEPTH_CELLS+1);

    logic [CNT_W-1:0]  cells_held;
    logic              mem_we, mem_werr, commit;
    logic [SLOT_W-1:0] wslot, rslot;
    logic [IDX_W-1:0]  widx, ridx;
    logic              take, release_cell;

    cell_fifo_wr #(
        .CELL_WORDS (CELL_WORDS),
        .DEPTH_CELLS(DEPTH_CELLS)
    ) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sop      (wr_sop),
        .cells_held  (cells_held),
        .mem_we      (mem_we),
        .mem_wslot   (wslot),
        .mem_widx    (widx),
        .mem_werr    (mem_werr),
        .commit      (commit),
        .cell_space  (cell_space),
        .cell_written(cell_written),
        .oflw_err    (oflw_err),
        .soc_err     (soc_err)
    );

    cell_fifo_rd #(
        .CELL_WORDS (CELL_WORDS),
        .DEPTH_CELLS(DEPTH_CELLS)
    ) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_ena      (rd_ena),
        .cells_held  (cells_held),
        .rd_dav      (rd_dav),
        .take        (take),
        .release_cell(release_cell),
        .rslot       (rslot),
        .ridx        (ridx),
        .rd_val      (rd_val),
        .rd_sop      (rd_sop),
        .rd_eop      (rd_eop),
        .uflw_err    (uflw_err)
    );

    cell_fifo_store #(
        .DATA_W     (DATA_W),
        .CELL_WORDS (CELL_WORDS),
        .DEPTH_CELLS(DEPTH_CELLS)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .wslot(wslot),
        .widx (widx),
        .wdata(wr_data),
        .werr (mem_werr),
        .re   (take),
        .rslot(rslot),
        .ridx (ridx),
        .rdata(rd_data),
        .rerr (rd_err)
    );

    // committed cells not yet fully read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells_held <= '0;
        end else if (commit && !release_cell) begin
            cells_held <= cells_held + CNT_W'(1);
        end else if (!commit && release_cell) begin
            cells_held <= cells_held - CNT_W'(1);
        end
    end

endmodule

// File: rtl/cell_fifo_chk.sv
module cell_fifo_chk #(
    parameter int CELL_WORDS  = 13,
    parameter int DEPTH_CELLS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic cell_space,
    input logic cell_written,
    input logic oflw_err,
    input logic soc_err,
    input logic rd_ena,
    input logic rd_dav,
    input logic rd_val,
    input logic rd_sop,
    input logic rd_eop,
    input logic uflw_err
);
    int sh_cells;
    int exp_cells;
    int rd_word;

    always_comb begin
        exp_cells = sh_cells + (cell_written ? 1 : 0) - ((rd_val && rd_eop) ? 1 : 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_cells <= 0;
            rd_word  <= 0;
        end else begin
            sh_cells <= exp_cells;
            if (rd_val) begin
                rd_word <= (rd_word == CELL_WORDS-1) ? 0 : rd_word + 1;
            end
        end
    end

    p_space_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_cells >= DEPTH_CELLS) |-> !cell_space);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oflw_err |-> $past(wr_en && !cell_space));

    p_written_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cell_written |=> !cell_written);

    p_dav_tracks_cells_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dav == (exp_cells != 0));

    p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ena && !rd_dav) |=> (uflw_err && !rd_val));

    p_read_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ena && rd_dav) |=> rd_val);

    p_read_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ena |=> !rd_val);

    p_sop_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_val |-> (rd_sop == (rd_word == 0)));

    p_eop_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_val |-> (rd_eop == (rd_word == CELL_WORDS-1)));

    p_soc_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soc_err |-> $past(wr_en));

endmodule

bind cell_fifo cell_fifo_chk #(
    .CELL_WORDS (CELL_WORDS),
    .DEPTH_CELLS(DEPTH_CELLS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .cell_space  (cell_space),
    .cell_written(cell_written),
    .oflw_err    (oflw_err),
    .soc_err     (soc_err),
    .rd_ena      (rd_ena),
    .rd_dav      (rd_dav),
    .rd_val      (rd_val),
    .rd_sop      (rd_sop),
    .rd_eop      (rd_eop),
    .uflw_err    (uflw_err)
);

// File: tb/tb_cell_fifo.sv
module tb_cell_fifo;
    localparam int DW = 32;
    localparam int CW = 13;
    localparam int DC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_sop = 1'b0, rd_ena = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          cell_space, cell_written, oflw_err, soc_err;
    logic          rd_dav, rd_val, rd_sop, rd_eop, rd_err, uflw_err;
    logic [DW-1:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int q_id[$];
    bit q_err[$];

    always #2 clk = ~clk;

    cell_fifo #(.DATA_W(DW), .CELL_WORDS(CW), .DEPTH_CELLS(DC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sop(wr_sop), .wr_data(wr_data),
        .cell_space(cell_space), .cell_written(cell_written), .oflw_err(oflw_err),
        .soc_err(soc_err), .rd_ena(rd_ena), .rd_dav(rd_dav), .rd_val(rd_val),
        .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_err(rd_err),
        .uflw_err(uflw_err)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [DW-1:0] word_of(input int id, input int k);
        return {id[15:0], k[15:0]};
    endfunction

    task automatic put(input bit sop, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_sop = sop; wr_data = d;
        step();
        wr_en = 1'b0; wr_sop = 1'b0;
    endtask

    // busy: a cell is already being collected when word 0 arrives
    task automatic send_cell(input int id, input bit first_sop, input bit exp_soc, input bit busy);
        for (int k = 0; k < CW; k++) begin
            check("R2 cell_space", cell_space,
                  ((q_id.size() + ((k > 0 || busy) ? 1 : 0)) < DC) ? 1 : 0);
            put((k == 0) ? first_sop : 1'b0, word_of(id, k));
            if (k == 0) check(first_sop ? "R9 soc_err" : "R10 soc_err", soc_err, exp_soc);
            if (k < CW-1) begin
                check("R4 no early cell_written", cell_written, 0);
                check("R5 rd_dav before last word", rd_dav, (q_id.size() != 0) ? 1 : 0);
            end
        end
        q_id.push_back(id);
        q_err.push_back(!first_sop);
        check("R4 cell_written", cell_written, 1);
        check("R5 rd_dav after commit", rd_dav, 1);
    endtask

    task automatic get_cell(input bit stall);
        int id;
        bit er;
        id = q_id.pop_front();
        er = q_err.pop_front();
        for (int k = 0; k < CW; k++) begin
            if (stall && k == 6) begin
                rd_ena = 1'b0;
                step();
                check("R7 rd_val low when idle", rd_val, 0);
            end
            rd_ena = 1'b1;
            step();
            check("R7 rd_val", rd_val, 1);
            check("R11 rd_data", rd_data, word_of(id, k));
            check("R8 rd_sop", rd_sop, (k == 0) ? 1 : 0);
            check("R8 rd_eop", rd_eop, (k == CW-1) ? 1 : 0);
            check("R10 rd_err", rd_err, er);
        end
        rd_ena = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 cell_space", cell_space, 1);
        check("R1 rd_dav", rd_dav, 0);
        check("R1 rd_val", rd_val, 0);
        check("R1 cell_written", cell_written, 0);
        check("R1 oflw_err", oflw_err, 0);
        check("R1 soc_err", soc_err, 0);
        check("R1 uflw_err", uflw_err, 0);

        // R6 underflow on empty
        rd_ena = 1'b1;
        step();
        check("R6 uflw_err", uflw_err, 1);
        check("R6 rd_val", rd_val, 0);
        rd_ena = 1'b0;
        step();
        check("R6 uflw_err clears", uflw_err, 0);

        // single cell with a read stall
        send_cell(1, 1'b1, 1'b0, 1'b0);
        get_cell(1'b1);
        check("R5 rd_dav after drain", rd_dav, 0);

        // fill to depth, then attempt one more
        for (int c = 0; c < DC; c++) send_cell(10 + c, 1'b1, 1'b0, 1'b0);
        check("R2 full cell_space", cell_space, 0);
        put(1'b1, word_of(99, 0));
        check("R3 oflw_err", oflw_err, 1);
        for (int k = 1; k < CW; k++) begin
            put(1'b0, word_of(99, k));
            check("R3 dropped no cell_written", cell_written, 0);
            check("R3 oflw single pulse", oflw_err, 0);
            check("R3 no soc_err in drop", soc_err, 0);
        end
        check("R3 rd_dav still set", rd_dav, 1);
        for (int c = 0; c < DC; c++) get_cell(1'b0);
        check("R3 dropped cell absent", rd_dav, 0);
        rd_ena = 1'b1;
        step();
        check("R3 empty after drain uflw", uflw_err, 1);
        rd_ena = 1'b0;
        step();

        // R9 misplaced start at every word position
        for (int p = 1; p < CW; p++) begin
            for (int k = 0; k < p; k++) begin
                put((k == 0) ? 1'b1 : 1'b0, word_of(200 + p, k));
                if (k == 0) check("R9 clean start", soc_err, 0);
            end
            send_cell(300 + p, 1'b1, 1'b1, 1'b1);
            check("R9 only one cell queued", q_id.size(), 1);
            get_cell(1'b0);
            check("R9 partial cell gone", rd_dav, 0);
        end

        // R10 missing start marker, then a clean cell
        send_cell(500, 1'b0, 1'b1, 1'b0);
        send_cell(501, 1'b1, 1'b0, 1'b0);
        get_cell(1'b0);
        get_cell(1'b1);
        check("R11 all drained", rd_dav, 0);

        finish_run();
    end

endmodule